// File: doc/BRIEF.md
# Multi-Mode Master CORDIC Engine

This block is the angle-finding element of a Givens-rotation array. It is an iterative fixed-point CORDIC unit. It takes a two's complement x/y pair and performs a fixed number of micro-rotations, one per clock cycle. It then presents the final x/y pair. A mode input selects one of three operations:

- **Circular vectoring** rotates the pair onto the x axis. The final x is the gain-scaled magnitude.
- **Circular rotation** turns the pair by an angle. The angle is given as a caller-supplied vector of per-iteration direction bits.
- **Hyperbolic vectoring** drives y toward zero in hyperbolic coordinates.

The unit does not accumulate an angle in radians. In the vectoring modes it publishes the direction bit chosen at each iteration. Follower rotation units can then repeat the same rotation on other data. The engine also keeps the full direction vector at the end of an operation.

The control is a three-state machine: `IDLE`, `RUN` and `FIN`.

- `IDLE` waits. A `start` pulse takes the *launch* transition to `RUN`, which latches the operands.
- `RUN` performs one micro-rotation per cycle. It loops on itself (*step*) until the last iteration.
- At the last iteration, the *finish* transition leads to `FIN`. `FIN` lasts one cycle and raises `done`.
- From `FIN`, the *relaunch* transition (a `start` in that cycle) goes back to `RUN`. Without a `start`, *retire* returns to `IDLE`.

The results hold until the next accepted start.

Top module: `cordic_master`

## Requirements
- R1: After reset, `busy`, `done`, `dir_valid`, `x_out`, `y_out` and `dir_out` are all zero.
- R2: A start accepted on a clock edge gives `done` high for exactly one cycle, after ITERS (10) further rising edges. `busy` is high during the ITERS cycles in between. `busy` and `done` are never high together.
- R3: Mode 2'b00 (circular vectoring) uses shift amount i at iteration i (i = 0..ITERS-1). The direction bit is 1 when the sign bits of x and y are equal, and 0 otherwise.
  - Bit 1 gives y ← y − (x>>>i) and x ← x + (y>>>i).
  - Bit 0 gives y ← y + (x>>>i) and x ← x − (y>>>i).
  - All updates use the values from before the iteration, with 15-bit wrap-around arithmetic.
- R4: In circular vectoring with x > 0 and |x|, |y| < 4096, `x_out` is within 14 LSB of 1.64676·sqrt(x²+y²).
- R5: Mode 2'b01 (circular rotation) uses `dir_in[i]` as the direction bit of iteration i. It follows the same update rules as R3.
- R6: Mode 2'b10 (hyperbolic vectoring) chooses direction bits as in R3. It uses shift amount i+1 for i < 4, i for 4 ≤ i < 14, and i−1 beyond that, so the default shifts are 1,2,3,4,4,5,6,7,8,9.
  - The y update is as in R3.
  - The x update is inverted: bit 1 gives x ← x − (y>>>s), and bit 0 gives x ← x + (y>>>s).
  - Mode 2'b11 behaves as 2'b10.
- R7: In the vectoring modes, `dir_valid` is high during each `RUN` cycle, and `dir_bit` carries the direction bit of the iteration being performed, iteration 0 first. In rotation mode, `dir_valid` stays low. After `done`, `dir_out[i]` holds the direction bit used at iteration i.
- R8: `x_out`, `y_out` and `dir_out` hold their values from `done` until the next accepted start. A `start` seen while `busy` is high is ignored: the operation in flight finishes with unchanged timing and results.
- R9: Right shifts are arithmetic and are not masked. A small negative operand shifted past its magnitude contributes −1, and a small positive operand contributes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled when not busy |
| mode | input | 2 | 00 circular vectoring, 01 circular rotation, 1x hyperbolic vectoring |
| x_in | input | W (15) | Initial x, two's complement |
| y_in | input | W (15) | Initial y, two's complement |
| dir_in | input | ITERS (10) | Direction bits for rotation mode, bit i for iteration i |
| busy | output | 1 | High while iterations run |
| done | output | 1 | One-cycle completion pulse |
| dir_valid | output | 1 | `dir_bit` is a broadcast direction for followers |
| dir_bit | output | 1 | Direction bit of the current iteration |
| dir_out | output | ITERS (10) | Direction bits used by the last operation |
| x_out | output | W (15) | Final x |
| y_out | output | W (15) | Final y |

## Verification
Inputs change on falling edges, and `start` is raised for one cycle. The bench counts falling edges from the one on which `start` drops. `done`, the final x/y and `dir_out` are due on the tenth such edge. The per-iteration `dir_valid`/`dir_bit` are read on edges zero through nine, before `done` is due. One further falling edge later, `done` must be low again with the results unchanged. A second `start` injected mid-run must leave both that tenth-edge timing and the result untouched.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } ctl_state_t;

    localparam logic [1:0] OP_CIRC_VEC = 2'b00;
    localparam logic [1:0] OP_CIRC_ROT = 2'b01;
    localparam logic [1:0] OP_HYP_VEC  = 2'b10;

    // Hyperbolic index: starts at 1, indices 4 and 13 are visited twice.
    function automatic int hyp_shift(input int i);
        return i + 1 - ((i >= 4) ? 1 : 0) - ((i >= 14) ? 1 : 0);
    endfunction

endpackage

// File: rtl/cordic_dir_pick.sv
module cordic_dir_pick (
    input  logic rotate,
    input  logic x_sign,
    input  logic y_sign,
    input  logic ext_dir,
    output logic dir
);
    // Vectoring: same signs -> subtract x from y (bit 1) to pull y toward zero.
    always_comb begin
        dir = rotate ? ext_dir : ~(x_sign ^ y_sign);
    end
endmodule

// File: rtl/cordic_microrot.sv
module cordic_microrot #(
    parameter int W  = 15,
    parameter int SW = 4
) (
    input  logic signed [W-1:0]  x_cur,
    input  logic signed [W-1:0]  y_cur,
    input  logic        [SW-1:0] shamt,
    input  logic                 dir,
    input  logic                 hyp,
    output logic signed [W-1:0]  x_nxt,
    output logic signed [W-1:0]  y_nxt
);
    logic signed [W-1:0] x_sh, y_sh;
    logic                x_sub;

    always_comb begin
        x_sh  = x_cur >>> shamt;
        y_sh  = y_cur >>> shamt;
        // one XOR on the x add/subtract control covers both coordinate systems
        x_sub = ~dir ^ hyp;
        y_nxt = dir   ? (y_cur - x_sh) : (y_cur + x_sh);
        x_nxt = x_sub ? (x_cur - y_sh) : (x_cur + y_sh);
    end
endmodule

// File: rtl/cordic_master.sv
module cordic_master
    import cordic_pkg::*;
#(
    parameter int W     = 15,
    parameter int ITERS = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           mode,
    input  logic [W-1:0]         x_in,
    input  logic [W-1:0]         y_in,
    input  logic [ITERS-1:0]     dir_in,
    output logic                 busy,
    output logic                 done,
    output logic                 dir_valid,
    output logic                 dir_bit,
    output logic [ITERS-1:0]     dir_out,
    output logic [W-1:0]         x_out,
    output logic [W-1:0]         y_out
);
    localparam int SW = $clog2(W);
    localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

    ctl_state_t state_q, state_d;

    logic signed [W-1:0] x_q, y_q, x_nxt, y_nxt;
    logic [ITERS-1:0]    ext_q, dir_acc_q;
    logic [CW-1:0]       iter_q;
    logic                op_rot_q, op_hyp_q;
    logic                step_dir;
    logic [SW-1:0]       shamt;
    logic                accept;

    assign accept = start && (state_q != ST_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;                       // launch
            ST_RUN:  if (iter_q == LAST) state_d = ST_FIN;              // finish / step
            ST_FIN:  state_d = start ? ST_RUN : ST_IDLE;                // relaunch / retire
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        if (op_hyp_q) shamt = SW'(hyp_shift(int'(iter_q)));
        else          shamt = SW'(iter_q);
    end

    cordic_dir_pick u_pick (
        .rotate  (op_rot_q),
        .x_sign  (x_q[W-1]),
        .y_sign  (y_q[W-1]),
        .ext_dir (ext_q[iter_q]),
        .dir     (step_dir)
    );

    cordic_microrot #(.W(W), .SW(SW)) u_rot (
        .x_cur (x_q),
        .y_cur (y_q),
        .shamt (shamt),
        .dir   (step_dir),
        .hyp   (op_hyp_q),
        .x_nxt (x_nxt),
        .y_nxt (y_nxt)
    );

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q       <= '0;
            y_q       <= '0;
            ext_q     <= '0;
            dir_acc_q <= '0;
            iter_q    <= '0;
            op_rot_q  <= 1'b0;
            op_hyp_q  <= 1'b0;
        end else if (accept) begin
            x_q       <= x_in;
            y_q       <= y_in;
            ext_q     <= dir_in;
            dir_acc_q <= '0;
            iter_q    <= '0;
            op_rot_q  <= (mode == OP_CIRC_ROT);
            op_hyp_q  <= mode[1];
        end else if (state_q == ST_RUN) begin
            x_q               <= x_nxt;
            y_q               <= y_nxt;
            dir_acc_q[iter_q] <= step_dir;
            iter_q            <= iter_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q == ST_RUN);
        done      = (state_q == ST_FIN);
        dir_valid = busy && !op_rot_q;
        dir_bit   = busy && step_dir;
        dir_out   = dir_acc_q;
        x_out     = x_q;
        y_out     = y_q;
    end
endmodule

// File: rtl/cordic_master_chk.sv
module cordic_master_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       dir_valid,
    input logic       op_rot_q,
    input logic [14:0] x_out,
    input logic [14:0] y_out
);
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_after_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_launch_needs_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_hold_results_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(x_out) && $stable(y_out)));

    assert_bcast_only_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dir_valid |-> busy);

    assert_rot_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_rot_q) |-> !dir_valid);
endmodule

bind cordic_master cordic_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .dir_valid (dir_valid),
    .op_rot_q  (op_rot_q),
    .x_out     (x_out[14:0]),
    .y_out     (y_out[14:0])
);

// File: tb/tb_cordic_master.sv
module tb_cordic_master;
    localparam int W = 15;
    localparam int N = 10;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [W-1:0] x_in = '0, y_in = '0;
    logic [N-1:0] dir_in = '0;
    logic busy, done, dir_valid, dir_bit;
    logic [N-1:0] dir_out;
    logic [W-1:0] x_out, y_out;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cordic_master dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .x_in(x_in), .y_in(y_in), .dir_in(dir_in),
        .busy(busy), .done(done), .dir_valid(dir_valid), .dir_bit(dir_bit),
        .dir_out(dir_out), .x_out(x_out), .y_out(y_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Independent bit-exact model of the requirements R3, R5, R6, R9.
    task automatic model(input logic [1:0] md, input logic signed [W-1:0] xi,
                         input logic signed [W-1:0] yi, input logic [N-1:0] ext,
                         output logic signed [W-1:0] xo, output logic signed [W-1:0] yo,
                         output logic [N-1:0] bits);
        logic signed [W-1:0] x, y, xs, ys;
        bit b;
        int s;
        x = xi; y = yi; bits = '0;
        for (int i = 0; i < N; i++) begin
            if (md[1]) s = (i < 4) ? i + 1 : ((i < 14) ? i : i - 1);
            else       s = i;
            if (md == 2'b01) b = ext[i];
            else             b = (x[W-1] == y[W-1]);
            bits[i] = b;
            xs = x >>> s;
            ys = y >>> s;
            if (md[1]) begin
                if (b) begin x = x - ys; y = y - xs; end
                else   begin x = x + ys; y = y + xs; end
            end else begin
                if (b) begin x = x + ys; y = y - xs; end
                else   begin x = x - ys; y = y + xs; end
            end
        end
        xo = x; yo = y;
    endtask

    task automatic run_op(input logic [1:0] md, input logic signed [W-1:0] xi,
                          input logic signed [W-1:0] yi, input logic [N-1:0] ext,
                          input bit poke, input string tag);
        logic signed [W-1:0] ex, ey;
        logic [N-1:0] eb;
        logic [N-1:0] got_b, got_v;
        int k;
        logic [W-1:0] hx, hy;
        string rq;
        rq = (md == 2'b01) ? "R5" : (md[1] ? "R6" : "R3");
        model(md, xi, yi, ext, ex, ey, eb);
        @(negedge clk);
        mode = md; x_in = xi; y_in = yi; dir_in = ext; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_b = '0; got_v = '0;
        k = 0;
        while (!done && k < 40) begin
            if (k < N) begin got_b[k] = dir_bit; got_v[k] = dir_valid; end
            if (k == 0) chk(busy === 1'b1, "R2", {tag, " busy while running"}, busy, 1);
            if (poke && k == 3) begin start = 1'b1; x_in = ~xi; mode = ~md; end
            if (poke && k == 4) start = 1'b0;
            @(negedge clk);
            k++;
        end
        chk(k == N, "R2", {tag, " done latency"}, k, N);
        chk($signed(x_out) == ex, rq, {tag, " x_out"}, $signed(x_out), ex);
        chk($signed(y_out) == ey, rq, {tag, " y_out"}, $signed(y_out), ey);
        chk(dir_out == eb, "R7", {tag, " dir_out"}, dir_out, eb);
        if (md == 2'b01)
            chk(got_v == '0, "R7", {tag, " no broadcast in rotation"}, got_v, 0);
        else begin
            chk(got_v == '1, "R7", {tag, " dir_valid each step"}, got_v, {N{1'b1}});
            chk(got_b == eb, "R7", {tag, " broadcast bits"}, got_b, eb);
        end
        if (md == 2'b00 && xi > 0 && xi < 4096 && yi > -4096 && yi < 4096) begin
            real mag;
            int e;
            mag = $sqrt(real'(xi) * real'(xi) + real'(yi) * real'(yi)) * 1.646760258;
            e = int'(mag);
            chk(($signed(x_out) - e <= 14) && (e - $signed(x_out) <= 14), "R4",
                {tag, " magnitude"}, $signed(x_out), e);
        end
        hx = x_out; hy = y_out;
        @(negedge clk);
        chk(done === 1'b0, "R2", {tag, " done one cycle"}, done, 0);
        chk(x_out == hx && y_out == hy && dir_out == eb, "R8", {tag, " hold"}, x_out, hx);
    endtask

    initial begin
        void'($urandom(32'h1357));
        #1;
        chk(busy === 0 && done === 0 && dir_valid === 0, "R1", "reset flags", {busy, done, dir_valid}, 0);
        chk(x_out === 0 && y_out === 0 && dir_out === 0, "R1", "reset data", x_out, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy === 0 && done === 0, "R1", "idle after reset", {busy, done}, 0);

        // directed corners
        run_op(2'b00, 15'sd3000, 15'sd0, '0, 0, "R3 on-axis");
        run_op(2'b00, 15'sd1000, 15'sd1000, '0, 0, "R3 diagonal");
        run_op(2'b00, 15'sd4000, -15'sd4000, '0, 0, "R4 neg y");
        run_op(2'b00, -15'sd2000, 15'sd500, '0, 0, "R3 neg x");
        run_op(2'b01, -15'sd5, 15'sd3, '1, 0, "R9 small neg");
        run_op(2'b01, 15'sd2, -15'sd1, 10'b0101010101, 0, "R9 small mix");
        run_op(2'b01, 15'sd3000, 15'sd100, 10'b1100101001, 0, "R5 rotate");
        run_op(2'b10, 15'sd3000, 15'sd1200, '0, 0, "R6 hyp");
        run_op(2'b11, 15'sd2500, -15'sd900, '0, 0, "R6 mode11");
        run_op(2'b00, 15'sd0, 15'sd0, '0, 0, "R3 zero");
        run_op(2'b00, 15'sd2222, 15'sd777, '0, 1, "R8 start while busy");

        // constrained random
        for (int t = 0; t < 120; t++) begin
            logic [1:0] md;
            int xv, yv;
            md = 2'(t % 3);
            if (md == 2'b10) begin
                xv = 2048 + int'($urandom_range(2047));
                yv = int'($urandom_range(xv)) - xv / 2;
            end else begin
                xv = (md == 2'b00) ? 1 + int'($urandom_range(4094)) : int'($urandom_range(8190)) - 4095;
                yv = int'($urandom_range(8190)) - 4095;
            end
            run_op(md, W'(xv), W'(yv), N'($urandom), (t % 17) == 5, "random");
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule